// File: doc/BRIEF.md
# Sequential-Mode DMA Transfer Channel

This block is one DMA channel working in sequential mode. Software loads a memory address, a fixed peripheral (I/O) address, a transfer count and a control word. Once the channel is enabled, every request from the chosen activation source moves one byte or one 16-bit word. Each move is a read cycle on the bus master port followed by a write cycle. The control word also sets which way the data goes: from memory to the peripheral address, or from the peripheral address to memory.

After each move, the memory address steps up or down by the transfer size, while the peripheral address stays fixed. The count goes down by one. When the count runs out, the channel switches itself off. If the interrupt enable is set, it also raises an interrupt, which stays up until software acknowledges it. The parameter `EXT_OK` builds the channel variant that accepts the external request line. In the other variant that line is never accepted.

Top module: `seqdma_channel`

## Requirements
- R1: After reset the channel is off (`chan_on`=0), `irq`=0, `bus_req`=0 and all registers are zero. A write with `cfg_we`=1 loads the register chosen by `cfg_sel`: 0 = memory address, 1 = I/O address, 2 = count, 3 = control. The control bits are: bit0 enable, bit1 interrupt enable, bit2 decrement, bit3 word size, bit4 I/O-to-memory.
- R2: Each accepted request gives exactly one read cycle (`bus_wr`=0) and then one write cycle (`bus_wr`=1), in that order. The write carries the data returned by the read. In byte mode only bits 7:0 are carried and `bus_wdata[15:8]` is zero. Address and direction are held until `bus_ack`.
- R3: With control bit4 = 0 the read uses the memory address and the write uses the I/O address; with bit4 = 1 the two are swapped. The I/O address never changes. For the k-th transfer (k from 0) the memory address is L + s·k, where s = ±1 (byte) or ±2 (word), negative when the decrement bit is set. Addresses wrap modulo 2^ADDR_W.
- R4: Each completed transfer lowers the count by one. The transfer that takes the count from 1 to 0 clears the enable, and later requests start no bus cycle.
- R5: A count of zero gives 2^CNT_W transfers (65,536 with the default width) before the channel switches off.
- R6: Control bits 8:5 select the source: 0 ADC end, 1 serial transmit empty, 2 serial receive full, 3 to 8 timer channels 0 to 5, 9 external. Only the selected `src_req` bit counts. Code 9 is accepted only when `EXT_OK`=1. Codes 10 to 15 select nothing.
- R7: Requests that arrive while the channel is off are dropped. One request that arrives during a transfer is kept and served after that transfer.
- R8: If the interrupt enable is set when the count runs out, `irq` rises. It stays high until a control write clears the interrupt enable or sets the enable bit.
- R9: In word mode `bus_size`=1 and bit 0 of every bus address is driven 0, whatever the register holds.
- R10: The memory address register changes only on a software write or after the acknowledged write cycle of a transfer, so the first transfer uses L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | CFG_W | Register write data |
| src_req | input | 10 | Activation source request pulses, one per source code |
| bus_req | output | 1 | Bus cycle active |
| bus_wr | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_size | output | 1 | 1 = word, 0 = byte |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with bus_ack on a read |
| bus_ack | input | 1 | Bus cycle completion |
| chan_on | output | 1 | Channel enable state |
| irq | output | 1 | Transfer-end interrupt |

## Verification
The assertions rely on the following:
- Software does not write registers while a bus cycle is waiting for `bus_ack`. This is what makes the address-hold check meaningful.
- `bus_ack` comes only while `bus_req` is high.
- A request bit is high for one cycle per request.

The bench keeps within these limits. It writes registers only once the channel has gone idle, and its bus responder raises `bus_ack` only for an open cycle, after 0 to 2 random wait cycles, and then drops it. Requests are single-cycle pulses spaced well apart, except in the directed case that fires a second pulse on purpose while a transfer is in flight.

// File: rtl/seqdma_pkg.sv
package seqdma_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_READ  = 2'd1,
    XS_WRITE = 2'd2
  } xfer_state_e;

  localparam int NUM_SRC = 10;
  localparam int SRC_EXT = 9;
  localparam int SRC_W   = 4;
  localparam int DATA_W  = 16;

  localparam logic [1:0] SEL_MAR  = 2'd0;
  localparam logic [1:0] SEL_IOAR = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTL  = 2'd3;

  localparam int CTL_EN    = 0;
  localparam int CTL_IE    = 1;
  localparam int CTL_DEC   = 2;
  localparam int CTL_WORD  = 3;
  localparam int CTL_TOMEM = 4;
  localparam int CTL_SRC   = 5;
  localparam int CTL_BITS  = CTL_SRC + SRC_W;

endpackage

// File: rtl/seqdma_regs.sv
module seqdma_regs
  import seqdma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] mar,
  output logic [ADDR_W-1:0] ioar,
  output logic [CNT_W-1:0]  cnt,
  output logic              en,
  output logic              word,
  output logic              dec,
  output logic              to_mem,
  output logic [SRC_W-1:0]  src_sel,
  output logic              irq
);

  logic [ADDR_W-1:0] mar_d, ioar_d, step;
  logic [CNT_W-1:0]  cnt_d;
  logic              en_d, ie, ie_d, word_d, dec_d, to_mem_d, irqf, irqf_d;
  logic [SRC_W-1:0]  src_d;

  assign step = word ? ADDR_W'(2) : ADDR_W'(1);

  always_comb begin
    mar_d    = mar;
    ioar_d   = ioar;
    cnt_d    = cnt;
    en_d     = en;
    ie_d     = ie;
    word_d   = word;
    dec_d    = dec;
    to_mem_d = to_mem;
    src_d    = src_sel;
    irqf_d   = irqf;
    if (xfer_done) begin
      mar_d = dec ? (mar - step) : (mar + step);
      cnt_d = cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) begin
        en_d = 1'b0;
        if (ie) irqf_d = 1'b1;
      end
    end
    if (cfg_we) begin
      case (cfg_sel)
        SEL_MAR:  mar_d  = cfg_wdata[ADDR_W-1:0];
        SEL_IOAR: ioar_d = cfg_wdata[ADDR_W-1:0];
        SEL_CNT:  cnt_d  = cfg_wdata[CNT_W-1:0];
        default: begin
          en_d     = cfg_wdata[CTL_EN];
          ie_d     = cfg_wdata[CTL_IE];
          dec_d    = cfg_wdata[CTL_DEC];
          word_d   = cfg_wdata[CTL_WORD];
          to_mem_d = cfg_wdata[CTL_TOMEM];
          src_d    = cfg_wdata[CTL_SRC +: SRC_W];
          if (cfg_wdata[CTL_EN] || !cfg_wdata[CTL_IE]) irqf_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar <= '0; ioar <= '0; cnt <= '0; en <= 1'b0; ie <= 1'b0;
      word <= 1'b0; dec <= 1'b0; to_mem <= 1'b0; src_sel <= '0; irqf <= 1'b0;
    end else begin
      mar <= mar_d; ioar <= ioar_d; cnt <= cnt_d; en <= en_d; ie <= ie_d;
      word <= word_d; dec <= dec_d; to_mem <= to_mem_d; src_sel <= src_d;
      irqf <= irqf_d;
    end
  end

  assign irq = irqf & ie;

  p_end_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && (cnt == CNT_W'(1)) && !cfg_we |=> !en);

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !cfg_we |=> irq);

  p_mar_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mar) |-> ($past(cfg_we) || $past(xfer_done)));

endmodule

// File: rtl/seqdma_req.sv
module seqdma_req
  import seqdma_pkg::*;
#(
  parameter bit EXT_OK = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [SRC_W-1:0]   src_sel,
  input  logic               en,
  input  logic               take,
  output logic               pend
);

  logic hit, pend_d;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if ((src_sel == SRC_W'(i)) && (EXT_OK || (i != SRC_EXT))) hit = hit | src_req[i];
    end
  end

  assign pend_d = en & (hit | (pend & ~take));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

endmodule

// File: rtl/seqdma_xfer.sv
module seqdma_xfer
  import seqdma_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend,
  input  logic              en,
  input  logic [ADDR_W-1:0] mar,
  input  logic [ADDR_W-1:0] ioar,
  input  logic              word,
  input  logic              to_mem,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              take,
  output logic              done,
  output logic              bus_req,
  output logic              bus_wr,
  output logic              bus_size,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata
);

  xfer_state_e       state, state_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic [ADDR_W-1:0] raw_addr;

  always_comb begin
    state_d = state;
    buf_d   = buf_q;
    take    = 1'b0;
    done    = 1'b0;
    case (state)
      XS_IDLE: if (pend && en) begin
        state_d = XS_READ;
        take    = 1'b1;
      end
      XS_READ: if (bus_ack) begin
        state_d = XS_WRITE;
        buf_d   = word ? bus_rdata : {8'h00, bus_rdata[7:0]};
      end
      XS_WRITE: if (bus_ack) begin
        state_d = XS_IDLE;
        done    = 1'b1;
      end
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= XS_IDLE;
      buf_q <= '0;
    end else begin
      state <= state_d;
      buf_q <= buf_d;
    end
  end

  assign bus_req   = (state != XS_IDLE);
  assign bus_wr    = (state == XS_WRITE);
  assign bus_size  = word;
  assign bus_wdata = buf_q;
  assign raw_addr  = (bus_wr ^ to_mem) ? ioar : mar;
  assign bus_addr  = {raw_addr[ADDR_W-1:1], raw_addr[0] & ~word};

  p_start_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> (!bus_wr && en));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wr));

  p_one_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_wr && bus_ack |=> !bus_req);

endmodule

// File: rtl/seqdma_channel.sv
module seqdma_channel
  import seqdma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter bit EXT_OK = 1'b1,
  parameter int CFG_W  = (ADDR_W > CNT_W) ? ((ADDR_W > CTL_BITS) ? ADDR_W : CTL_BITS)
                                          : ((CNT_W > CTL_BITS) ? CNT_W : CTL_BITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic [NUM_SRC-1:0] src_req,
  output logic               bus_req,
  output logic               bus_wr,
  output logic               bus_size,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_rdata,
  input  logic               bus_ack,
  output logic               chan_on,
  output logic               irq
);

  logic [1:0]        rst_sync;
  logic              rst_n_i;
  logic [ADDR_W-1:0] mar, ioar;
  logic [CNT_W-1:0]  cnt;
  logic              en, word, dec, to_mem, pend, take, done;
  logic [SRC_W-1:0]  src_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  seqdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .xfer_done(done), .mar(mar), .ioar(ioar),
    .cnt(cnt), .en(en), .word(word), .dec(dec), .to_mem(to_mem),
    .src_sel(src_sel), .irq(irq)
  );

  seqdma_req #(.EXT_OK(EXT_OK)) u_req (
    .clk(clk), .rst_n(rst_n_i), .src_req(src_req), .src_sel(src_sel),
    .en(en), .take(take), .pend(pend)
  );

  seqdma_xfer #(.ADDR_W(ADDR_W)) u_xfer (
    .clk(clk), .rst_n(rst_n_i), .pend(pend), .en(en), .mar(mar), .ioar(ioar),
    .word(word), .to_mem(to_mem), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .take(take), .done(done), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  assign chan_on = en;

endmodule

// File: tb/test_seqdma_channel.sv
module test_seqdma_channel;

  localparam int AW = 24;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [23:0] cfg_wdata;
  logic [9:0]  src_req;
  logic        bus_req, bus_wr, bus_size, bus_ack, chan_on, irq;
  logic [AW-1:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        a_req, a_wr, a_size, a_on, a_irq;
  logic [AW-1:0] a_addr;
  logic [15:0] a_wdata;

  int checks = 0, failures = 0;
  int xfers = 0, reads = 0, a_writes = 0, lat = 0;
  logic [AW-1:0] t_l, t_io, rd_addr;
  logic t_dec, t_word, t_tomem;

  always #4 clk = ~clk;

  seqdma_channel #(.ADDR_W(AW), .CNT_W(CW), .EXT_OK(1'b1)) i_seqdma_channel (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .src_req(src_req), .bus_req(bus_req),
    .bus_wr(bus_wr), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .chan_on(chan_on), .irq(irq)
  );

  seqdma_channel #(.ADDR_W(AW), .CNT_W(CW), .EXT_OK(1'b0)) i_seqdma_channel_a (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .src_req(src_req), .bus_req(a_req),
    .bus_wr(a_wr), .bus_size(a_size), .bus_addr(a_addr),
    .bus_wdata(a_wdata), .bus_rdata(16'h0000), .bus_ack(1'b1),
    .chan_on(a_on), .irq(a_irq)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_pat(input logic [AW-1:0] a);
    return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'hC3A5;
  endfunction

  function automatic logic [AW-1:0] mem_at(input int k);
    logic [AW-1:0] a, s;
    s = AW'(k) * (t_word ? AW'(2) : AW'(1));
    a = t_word ? {t_l[AW-1:1], 1'b0} : t_l;
    a = t_dec ? (a - s) : (a + s);
    return a;
  endfunction

  function automatic logic [AW-1:0] io_at();
    return t_word ? {t_io[AW-1:1], 1'b0} : t_io;
  endfunction

  // bus responder and per-transfer checker
  always @(negedge clk) begin
    if (a_req && a_wr) a_writes++;
    if (!rst_n) begin
      bus_ack = 1'b0;
      lat = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0;
      lat = $urandom_range(0, 2);
    end else if (bus_req) begin
      if (lat > 0) lat--;
      else begin
        bus_ack = 1'b1;
        if (!bus_wr) begin
          rd_addr = bus_addr;
          bus_rdata = rd_pat(bus_addr);
          reads++;
        end else begin
          logic [AW-1:0] m, er, ew;
          logic [15:0] ed;
          m  = mem_at(xfers);
          er = t_tomem ? io_at() : m;
          ew = t_tomem ? m : io_at();
          ed = t_word ? rd_pat(er) : {8'h00, rd_pat(er)[7:0]};
          chk(rd_addr == er, "R3 R10 read address", 32'(rd_addr), 32'(er));
          chk(bus_addr == ew, "R3 R9 write address", 32'(bus_addr), 32'(ew));
          chk(bus_wdata == ed && bus_size == t_word, "R2 write data", 32'(bus_wdata), 32'(ed));
          xfers++;
        end
      end
    end
  end

  task automatic wr_reg(input logic [1:0] sel, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [23:0] ctl(input bit en, input bit ie, input bit dec,
                                       input bit word, input bit tomem, input int src);
    return 24'({4'(src), tomem, word, dec, ie, en});
  endfunction

  task automatic pulse(input int src);
    @(negedge clk);
    src_req[src] = 1'b1;
    @(negedge clk);
    src_req = '0;
  endtask

  task automatic run_case(input logic [AW-1:0] l, input logic [AW-1:0] io, input int cnt,
                          input bit dec, input bit word, input bit tomem,
                          input int src, input bit ie);
    int n;
    t_l = l; t_io = io; t_dec = dec; t_word = word; t_tomem = tomem;
    xfers = 0;
    n = (cnt == 0) ? (1 << CW) : cnt;
    wr_reg(2'd0, 24'(l));
    wr_reg(2'd1, 24'(io));
    wr_reg(2'd2, 24'(cnt & ((1 << CW) - 1)));
    wr_reg(2'd3, ctl(1'b1, ie, dec, word, tomem, src));
    for (int i = 0; i < n + 2; i++) begin
      pulse(src);
      repeat (14) @(negedge clk);
      if (i == n - 2) chk(chan_on == 1'b1, cnt == 0 ? "R5 still on before last" : "R4 still on before last",
                          32'(chan_on), 32'd1);
    end
    chk(xfers == n, cnt == 0 ? "R5 transfer total" : "R4 transfer total", 32'(xfers), 32'(n));
    chk(chan_on == 1'b0, "R4 channel off at end", 32'(chan_on), 32'd0);
    chk(irq == ie, "R8 irq at end", 32'(irq), 32'(ie));
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; src_req = '0;
    bus_rdata = '0; bus_ack = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(chan_on == 1'b0 && irq == 1'b0 && bus_req == 1'b0, "R1 reset state",
        {29'd0, chan_on, irq, bus_req}, 32'd0);

    // R6 external source on both variants
    a_writes = 0;
    run_case(24'h000100, 24'h00F000, 3, 1'b0, 1'b0, 1'b0, 9, 1'b0);
    chk(a_writes == 0, "R6 external ignored without EXT_OK", 32'(a_writes), 32'd0);

    // R6 unselected source ignored
    xfers = 0;
    wr_reg(2'd2, 24'd4);
    wr_reg(2'd3, ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3));
    pulse(0); pulse(9); repeat (14) @(negedge clk);
    chk(xfers == 0, "R6 other source ignored", 32'(xfers), 32'd0);
    wr_reg(2'd3, ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12));
    pulse(0); pulse(3); repeat (14) @(negedge clk);
    chk(xfers == 0, "R6 code above 9 selects nothing", 32'(xfers), 32'd0);

    // R7 dropped while off
    reads = 0;
    wr_reg(2'd3, ctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0));
    pulse(0); repeat (14) @(negedge clk);
    chk(reads == 0, "R7 request while off dropped", 32'(reads), 32'd0);

    // R7 one request held during a transfer
    t_l = 24'h000200; t_io = 24'h00F010; t_dec = 1'b0; t_word = 1'b0; t_tomem = 1'b0;
    xfers = 0;
    wr_reg(2'd0, 24'h000200); wr_reg(2'd1, 24'h00F010); wr_reg(2'd2, 24'd5);
    wr_reg(2'd3, ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0));
    a_writes = 0;
    pulse(0); @(negedge clk); pulse(0);
    repeat (30) @(negedge clk);
    chk(xfers == 2, "R7 request held during transfer", 32'(xfers), 32'd2);
    chk(chan_on == 1'b1, "R4 still on mid count", 32'(chan_on), 32'd1);
    chk(a_writes == 2, "R6 other variant serves normal source", 32'(a_writes), 32'd2);

    // R8 interrupt hold and release paths
    run_case(24'h000300, 24'h00F020, 2, 1'b1, 1'b1, 1'b1, 2, 1'b1);
    repeat (20) @(negedge clk);
    chk(irq == 1'b1, "R8 irq held", 32'(irq), 32'd1);
    wr_reg(2'd3, ctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0));
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq cleared by interrupt enable off", 32'(irq), 32'd0);
    run_case(24'h000400, 24'h00F030, 1, 1'b0, 1'b0, 1'b0, 1, 1'b1);
    wr_reg(2'd3, ctl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 15));
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq cleared by re-arm", 32'(irq), 32'd0);
    wr_reg(2'd3, ctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0));

    // R9 odd start in word mode, R3 decrement wrap
    run_case(24'h001235, 24'h00F041, 4, 1'b0, 1'b1, 1'b0, 4, 1'b0);
    run_case(24'h000001, 24'h00F050, 3, 1'b1, 1'b0, 1'b1, 5, 1'b0);

    // R5 zero count
    run_case(24'h002000, 24'h00F060, 0, 1'b0, 1'b0, 1'b0, 6, 1'b0);

    // constrained random cases
    for (int r = 0; r < 10; r++) begin
      run_case(24'($urandom), 24'($urandom), $urandom_range(1, 6), 1'($urandom),
               1'($urandom), 1'($urandom), $urandom_range(0, 9), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule